// File: doc/BRIEF.md
# Inbound and Outbound PCI Address Translator

This block converts addresses that cross between the on-chip system bus and PCI space. Six programmable target windows let PCI masters reach system memory: each window pairs a system base with a PCI base over a power-of-two span. When a device-side lookup arrives with a system address, the block finds the lowest-numbered window that contains it and returns the matching PCI address and the window index. Windows are written through a small programming port, and both bases are forced down to a multiple of the span as they are stored.

For CPU-side requests the block checks rather than maps. A memory address must fall inside the memory window, and it passes through unchanged. When the I/O window base lies strictly inside the memory window, the memory window ends at that I/O base. An I/O address inside a fixed legal range is moved into the I/O window by adding the I/O base. A configuration offset is moved into the configuration window, which sits one 64 KiB step above the I/O base and is 64 KiB long.

A request is a one-cycle strobe with an address, a kind and a direction bit. The answer, with an error flag, appears on the registered response one cycle later.

Top module: `pax_xlat`

## Requirements
- R1: After reset `rsp_valid` is 0. `rsp_valid` is 1 in exactly the cycle that follows a cycle with `req_valid` at 1, and 0 otherwise.
- R2: A pulse on `cfg_we` stores entry `cfg_idx` (0 to 5). Both bases are ANDed with ~(`cfg_size` − 1), and the size is kept as written. An entry with size 0 matches nothing.
- R3: A request with `req_kind` 0 (memory) and `req_dma` 1 returns `(addr − sys_base) + pci_base` of a matching entry, with the entry index on `rsp_bar`. An entry matches when sys_base ≤ addr < sys_base + size. If no entry matches, the response is an error.
- R4: When several entries match, the entry with the lowest index wins.
- R5: The window bounds are computed without 32-bit wraparound, so an entry that ends at the top of the address space matches addresses up to 0xFFFFFFFF.
- R6: A request with `req_kind` 0 and `req_dma` 0 returns the address unchanged when win_start ≤ addr < effective end. Otherwise it is an error.
- R7: The effective end is `io_base` when win_start < io_base < win_end − 1. Otherwise the effective end is `win_end`.
- R8: A request with `req_kind` 1 (I/O) and `req_dma` 0 succeeds when 0x100 ≤ addr ≤ 0x10000, and returns addr + `io_base`. Otherwise it is an error.
- R9: Every request with `req_kind` 1 or 2 and `req_dma` 1 is an error. Every request with `req_kind` 3 is an error, whatever `req_dma` is.
- R10: A request with `req_kind` 2 (configuration) and `req_dma` 0 succeeds when addr < 0x10000, and returns io_base + 0x10000 + addr. Otherwise it is an error.
- R11: An error response has `rsp_err` 1, `rsp_addr` 0 and `rsp_bar` 7. A successful response that is not a window lookup has `rsp_bar` 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one target window entry |
| cfg_idx | input | 3 | Index of the entry to write |
| cfg_sys_base | input | 32 | System base of the entry |
| cfg_pci_base | input | 32 | PCI base of the entry |
| cfg_size | input | 32 | Span in bytes, a power of two; 0 disables the entry |
| win_start | input | 32 | First address of the memory window |
| win_end | input | 32 | End of the memory window, exclusive |
| io_base | input | 32 | Base of the I/O window |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 reserved |
| req_dma | input | 1 | 1 for a device-side lookup, 0 for a CPU-side check |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Response is an error |
| rsp_addr | output | 32 | Translated address, 0 on error |
| rsp_bar | output | 3 | Index of the matching entry, 7 if there is none |

## Verification
A stored base that is not aligned to its span, or a wrong size, shows up as a wrong offset or a missed hit. It appears on the first lookup that reaches that entry, one cycle after the strobe. A broken priority shows up only where entries overlap, so the checks place an overlapping window on purpose. The window trim and the I/O bounds are off-by-one hazards, so the checks probe the addresses on each side of every bound. Each of these errors changes `rsp_addr`, `rsp_err` or `rsp_bar` in the response cycle itself.

// File: rtl/pax_pkg.sv
package pax_pkg;
    parameter int ADDR_W  = 32;
    parameter int NUM_BAR = 6;
    localparam int IDX_W  = $clog2(NUM_BAR + 1);
    localparam logic [IDX_W-1:0] NO_BAR = '1;

    localparam logic [ADDR_W-1:0] IO_LO    = ADDR_W'(32'h0000_0100);
    localparam logic [ADDR_W-1:0] IO_HI    = ADDR_W'(32'h0001_0000);
    localparam logic [ADDR_W-1:0] CFG_OFS  = ADDR_W'(32'h0001_0000);
    localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(32'h0001_0000);

    typedef enum logic [1:0] {
        KIND_MEM = 2'd0,
        KIND_IO  = 2'd1,
        KIND_CFG = 2'd2,
        KIND_RSV = 2'd3
    } kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] sys_base;
        logic [ADDR_W-1:0] pci_base;
        logic [ADDR_W-1:0] size;
    } bar_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  bar;
    } rsp_t;
endpackage

// File: rtl/pax_bar_entry.sv
module pax_bar_entry
    import pax_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_sys_base,
    input  logic [ADDR_W-1:0] cfg_pci_base,
    input  logic [ADDR_W-1:0] cfg_size,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat
);
    bar_t              entry_d, entry_q;
    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W:0]   top_excl;

    always_comb begin
        entry_d    = entry_q;
        align_mask = ~(cfg_size - ADDR_W'(1));
        if (cfg_we && (cfg_idx == IDX_W'(IDX))) begin
            entry_d.sys_base = cfg_sys_base & align_mask;
            entry_d.pci_base = cfg_pci_base & align_mask;
            entry_d.size     = cfg_size;
        end
        top_excl = {1'b0, entry_q.sys_base} + {1'b0, entry_q.size};
        hit  = (entry_q.size != '0) && (look_addr >= entry_q.sys_base)
               && ({1'b0, look_addr} < top_excl);
        xlat = (look_addr - entry_q.sys_base) + entry_q.pci_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) entry_q <= '0;
        else        entry_q <= entry_d;
    end

    // R2: a stored window is aligned to its own span
    a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_q.size != '0) |->
        ((entry_q.sys_base & (entry_q.size - ADDR_W'(1))) == '0));

    // R2: a written entry takes its span on the next cycle
    a_r2_size_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_idx == IDX_W'(IDX))) |=> (entry_q.size == $past(cfg_size)));
endmodule

// File: rtl/pax_bar_select.sv
module pax_bar_select
    import pax_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BAR-1:0] hit_vec,
    input  logic [ADDR_W-1:0]  xlat_arr [NUM_BAR],
    output logic               sel_any,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [ADDR_W-1:0]  sel_addr
);
    always_comb begin
        sel_any  = 1'b0;
        sel_idx  = NO_BAR;
        sel_addr = '0;
        for (int i = NUM_BAR - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_any  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_addr = xlat_arr[i];
            end
        end
    end

    // R4: the chosen entry matches and no lower entry does
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> (hit_vec[sel_idx] &&
        ((hit_vec & ((NUM_BAR'(1) << sel_idx) - NUM_BAR'(1))) == '0)));

    // R3: with no match the selector reports no entry
    a_r3_none: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (sel_idx == NO_BAR));
endmodule

// File: rtl/pax_out_check.sv
module pax_out_check
    import pax_pkg::*;
(
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_start,
    input  logic [ADDR_W-1:0] win_end,
    input  logic [ADDR_W-1:0] io_base,
    output logic              ok,
    output logic [ADDR_W-1:0] out_addr
);
    logic              trim;
    logic [ADDR_W-1:0] eff_end;

    always_comb begin
        trim     = (io_base > win_start) && (io_base < (win_end - ADDR_W'(1)));
        eff_end  = trim ? io_base : win_end;
        ok       = 1'b0;
        out_addr = '0;
        unique case (kind)
            KIND_MEM: begin
                ok       = (addr >= win_start) && (addr < eff_end);
                out_addr = addr;
            end
            KIND_IO: begin
                ok       = (addr >= IO_LO) && (addr <= IO_HI);
                out_addr = addr + io_base;
            end
            KIND_CFG: begin
                ok       = addr < CFG_SPAN;
                out_addr = io_base + CFG_OFS + addr;
            end
            default: begin
                ok       = 1'b0;
                out_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/pax_xlat.sv
module pax_xlat
    import pax_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [pax_pkg::IDX_W-1:0] cfg_idx,
    input  logic [31:0]               cfg_sys_base,
    input  logic [31:0]               cfg_pci_base,
    input  logic [31:0]               cfg_size,
    input  logic [31:0]               win_start,
    input  logic [31:0]               win_end,
    input  logic [31:0]               io_base,
    input  logic                      req_valid,
    input  logic [1:0]                req_kind,
    input  logic                      req_dma,
    input  logic [31:0]               req_addr,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [31:0]               rsp_addr,
    output logic [pax_pkg::IDX_W-1:0] rsp_bar
);
    logic [NUM_BAR-1:0] hit_vec;
    logic [ADDR_W-1:0]  xlat_arr [NUM_BAR];
    logic               sel_any;
    logic [IDX_W-1:0]   sel_idx;
    logic [ADDR_W-1:0]  sel_addr;
    logic               out_ok;
    logic [ADDR_W-1:0]  out_addr;
    kind_e              kind;
    rsp_t               rsp_d, rsp_q;

    assign kind = kind_e'(req_kind);

    for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
        pax_bar_entry #(.IDX(g)) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_we       (cfg_we),
            .cfg_idx      (cfg_idx),
            .cfg_sys_base (cfg_sys_base),
            .cfg_pci_base (cfg_pci_base),
            .cfg_size     (cfg_size),
            .look_addr    (req_addr),
            .hit          (hit_vec[g]),
            .xlat         (xlat_arr[g])
        );
    end

    pax_bar_select u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .xlat_arr (xlat_arr),
        .sel_any  (sel_any),
        .sel_idx  (sel_idx),
        .sel_addr (sel_addr)
    );

    pax_out_check u_out (
        .kind      (kind),
        .addr      (req_addr),
        .win_start (win_start),
        .win_end   (win_end),
        .io_base   (io_base),
        .ok        (out_ok),
        .out_addr  (out_addr)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.err  = 1'b1;
            rsp_d.addr = '0;
            rsp_d.bar  = NO_BAR;
            if (req_dma) begin
                if ((kind == KIND_MEM) && sel_any) begin
                    rsp_d.err  = 1'b0;
                    rsp_d.addr = sel_addr;
                    rsp_d.bar  = sel_idx;
                end
            end else if (out_ok) begin
                rsp_d.err  = 1'b0;
                rsp_d.addr = out_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{valid: 1'b0, err: 1'b0, addr: '0, bar: NO_BAR};
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_bar   = rsp_q.bar;

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r9_dma_io_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dma && (req_kind != 2'd0)) |=> rsp_err);
    a_r11_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ((rsp_addr == '0) && (rsp_bar == NO_BAR)));
    a_r6_mem_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dma && (req_kind == 2'd0)) |=>
        (rsp_err || (rsp_addr == $past(req_addr))));
endmodule

// File: tb/pax_xlat_bench.sv
`timescale 1ns/1ps
module pax_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_sys_base = '0, cfg_pci_base = '0, cfg_size = '0;
    logic [31:0] win_start = '0, win_end = '0, io_base = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_dma = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_bar;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic        err;
        logic [31:0] addr;
        logic [2:0]  bar;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_sys [6];
    logic [31:0] m_pci [6];
    logic [31:0] m_size [6];

    always #2.5 clk = ~clk;

    pax_xlat u_pax_xlat (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sys_base(cfg_sys_base), .cfg_pci_base(cfg_pci_base), .cfg_size(cfg_size),
        .win_start(win_start), .win_end(win_end), .io_base(io_base),
        .req_valid(req_valid), .req_kind(req_kind), .req_dma(req_dma), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_bar(rsp_bar)
    );

    task automatic prog(input int idx, input logic [31:0] s, input logic [31:0] p,
                        input logic [31:0] sz);
        @(negedge clk);
        req_valid    = 1'b0;
        cfg_we       = 1'b1;
        cfg_idx      = 3'(idx);
        cfg_sys_base = s;
        cfg_pci_base = p;
        cfg_size     = sz;
        m_sys[idx]   = s & ~(sz - 1);
        m_pci[idx]   = p & ~(sz - 1);
        m_size[idx]  = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [1:0] kind, input logic dma,
                         input logic [31:0] a, input string tag);
        exp_t e;
        logic [31:0] lo, hi;
        e.err = 1'b1; e.addr = '0; e.bar = 3'd7; e.tag = tag;
        if (kind == 2'd0 && dma) begin
            for (int i = 0; i < 6; i++) begin
                if (e.err && m_size[i] != 0 && a >= m_sys[i] && (a - m_sys[i]) < m_size[i]) begin
                    e.err = 1'b0; e.addr = a - m_sys[i] + m_pci[i]; e.bar = 3'(i);
                end
            end
        end else if (kind == 2'd0) begin
            lo = win_start;
            hi = (io_base > win_start && io_base < win_end - 1) ? io_base : win_end;
            if (a >= lo && a < hi) begin e.err = 1'b0; e.addr = a; end
        end else if (kind == 2'd1 && !dma) begin
            if (a >= 32'h100 && a <= 32'h10000) begin e.err = 1'b0; e.addr = a + io_base; end
        end else if (kind == 2'd2 && !dma) begin
            if (a < 32'h10000) begin e.err = 1'b0; e.addr = io_base + 32'h10000 + a; end
        end
        sb.push_back(e);
        req_valid = 1'b1; req_kind = kind; req_dma = dma; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                tests++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected response addr=%h", rsp_addr);
                end else begin
                    e = sb.pop_front();
                    if (rsp_err !== e.err || rsp_addr !== e.addr || rsp_bar !== e.bar) begin
                        fails++;
                        $display("FAIL %s actual err=%0b addr=%h bar=%0d expected err=%0b addr=%h bar=%0d",
                                 e.tag, rsp_err, rsp_addr, rsp_bar, e.err, e.addr, e.bar);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 6; i++) begin m_sys[i] = 0; m_pci[i] = 0; m_size[i] = 0; end
        repeat (3) @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++; $display("FAIL R1 reset rsp_valid actual=%b expected=0", rsp_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++; $display("FAIL R1 idle rsp_valid actual=%b expected=0", rsp_valid);
        end
        // R2 all entries disabled after reset
        drive(2'd0, 1'b1, 32'h4000_1000, "R2 empty table");
        // R2 bases masked on programming, R3 offset mapping
        prog(0, 32'h4000_1234, 32'h8000_0ABC, 32'h0000_1000);
        drive(2'd0, 1'b1, 32'h4000_1FFC, "R3 hit bar0 top word");
        drive(2'd0, 1'b1, 32'h4000_1000, "R2 aligned base");
        drive(2'd0, 1'b1, 32'h4000_2000, "R3 miss above bar0");
        // R4 overlapping entries
        prog(2, 32'h4000_0000, 32'h9000_0000, 32'h0001_0000);
        drive(2'd0, 1'b1, 32'h4000_1010, "R4 bar0 wins overlap");
        drive(2'd0, 1'b1, 32'h4000_3000, "R4 bar2 outside bar0");
        // R5 top of address space
        prog(5, 32'hFFFF_0000, 32'h1000_0000, 32'h0001_0000);
        drive(2'd0, 1'b1, 32'hFFFF_FFFF, "R5 top address");
        drive(2'd0, 1'b1, 32'h0000_0010, "R5 no wrap low");
        // R2 size zero disables
        prog(0, 32'h4000_1000, 32'h8000_0000, 32'h0);
        drive(2'd0, 1'b1, 32'h4000_1010, "R2 disabled bar0 falls to bar2");
        // R6 R7 memory window with trim
        win_start = 32'h8000_0000; win_end = 32'hC000_0000; io_base = 32'hA000_0000;
        drive(2'd0, 1'b0, 32'h9FFF_FFFC, "R7 below trimmed end");
        drive(2'd0, 1'b0, 32'hA000_0000, "R7 at trimmed end");
        drive(2'd0, 1'b0, 32'h7FFF_FFFF, "R6 below start");
        drive(2'd0, 1'b0, 32'h8000_0000, "R6 at start");
        io_base = 32'hD000_0000;
        drive(2'd0, 1'b0, 32'hBFFF_FFFF, "R7 untrimmed last byte");
        drive(2'd0, 1'b0, 32'hC000_0000, "R6 at end");
        // R8 I/O bounds
        io_base = 32'h2000_0000;
        drive(2'd1, 1'b0, 32'h0000_00FF, "R8 below low bound");
        drive(2'd1, 1'b0, 32'h0000_0100, "R8 low bound");
        drive(2'd1, 1'b0, 32'h0001_0000, "R8 high bound");
        drive(2'd1, 1'b0, 32'h0001_0001, "R8 above high bound");
        // R9 illegal combinations
        drive(2'd1, 1'b1, 32'h0000_0200, "R9 io device-side");
        drive(2'd2, 1'b1, 32'h0000_0004, "R9 cfg device-side");
        drive(2'd3, 1'b0, 32'h8000_0000, "R9 reserved kind");
        // R10 configuration window
        drive(2'd2, 1'b0, 32'h0000_FFFC, "R10 cfg last word");
        drive(2'd2, 1'b0, 32'h0001_0000, "R10 cfg out of range");
        // R11 error layout after success, back to back
        drive(2'd0, 1'b1, 32'h4000_3004, "R11 success before error");
        drive(2'd0, 1'b1, 32'h5000_0000, "R11 error clears fields");
        repeat (3) @(negedge clk);
        tests++;
        if (sb.size() != 0) begin
            fails++; $display("FAIL R1 missing responses actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule